// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block is the host-visible control face of one disk-controller bus-master DMA channel. Software reaches it through a byte-wide read/write port with eight byte offsets. It can read and write a command byte, a status byte and a 32-bit descriptor-table pointer. Setting the run bit starts a walk through a table of 8-byte descriptors in memory. The block issues one descriptor-fetch request at a time on a valid/ready interface. It advances the pointer as each entry is accepted, and it waits for the data side to finish each segment before it fetches the next one.

The walk ends in one of two ways. It ends normally when a segment flagged as the last entry completes. It ends early when software clears the run bit; that abort raises a one-cycle flush pulse so the data side discards anything already received. An aborted walk cannot be resumed. Setting the run bit again starts a new walk from whatever the pointer field holds at that moment.

The drive-interrupt and transfer-error inputs set sticky status flags. Software clears each flag by writing a 1 to it.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset every offset reads 00h, except offset 2, whose bit 7 reads the SIMPLEX parameter. After reset fetch_valid, active, dir_write and flush are all 0.
- R2: The command byte sits at offset 0. Bit 3 is the direction (1 = writes to system memory, driven on dir_write). Bit 0 is the run bit. All other bits read back 0 whatever was written.
- R3: The status byte sits at offset 2. Bit 7 is read-only and equals SIMPLEX. Bits 6 and 5 are read/write enable bits. Bits 4:3 read 0. Bit 0 is read-only and equals the active output.
- R4: Offsets 1 and 3 always read 00h, and writes to them change no other register.
- R5: The pointer sits at offsets 4 to 7, least significant byte at offset 4, and each byte is written on its own. Bits 1:0 always read 0.
- R6: Status bit 2 is set in the cycle after drive_irq is high. Writing 1 to it at offset 2 clears it; writing 0 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R7: Status bit 1 is set in the cycle after xfer_err is high, and it clears and prioritises exactly like bit 2.
- R8: Writing the run bit from 0 to 1 while idle makes active 1 after that edge. It also raises fetch_valid with fetch_addr equal to the pointer. Writing 1 while the run bit is already 1 starts nothing.
- R9: While fetch_valid is high and fetch_ready is low, fetch_valid and fetch_addr hold. At the edge where fetch_ready is high, the request drops and the pointer reads back 8 higher.
- R10: After an accepted entry, a segment_done pulse starts the next fetch at the advanced pointer. If fetch_last was high when that entry was accepted, the segment_done pulse clears active instead.
- R11: While active, writes to the direction bit and to any pointer byte are ignored.
- R12: Writing the run bit to 0 while active clears active and fetch_valid at that edge. It raises flush for exactly one cycle, and no further fetch happens. A later 0-to-1 write of the run bit fetches from the pointer as it then reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe for one byte |
| hst_addr | input | 3 | Host byte offset |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte at hst_addr (combinational) |
| fetch_valid | output | 1 | Descriptor fetch request |
| fetch_ready | input | 1 | Memory side accepts the fetch and returns the entry |
| fetch_addr | output | 32 | Address of the descriptor being fetched |
| fetch_last | input | 1 | Returned entry is the end of the table |
| segment_done | input | 1 | Data side finished the current entry |
| drive_irq | input | 1 | Drive interrupt event |
| xfer_err | input | 1 | Transfer error event |
| active | output | 1 | Bus master running |
| dir_write | output | 1 | Transfer direction, 1 = writes to system memory |
| flush | output | 1 | One-cycle pulse to discard received data on abort |

## Verification
The bench builds the block with SIMPLEX set to 1. This makes the read-only bit 7 distinguishable from the reset value and from the reserved bits.

All 256 values are swept through the command and status bytes, and the unused offsets are written with every value. The W1C flags are driven through set, keep, clear and same-cycle set-and-clear cases. A five-entry table walk with stalled handshakes, an early abort, a fresh restart from the advanced pointer, and a redundant run write all compute their expected addresses arithmetically from the base pointer.

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter bit SIMPLEX = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hst_wr,
  input  logic [2:0]  hst_addr,
  input  logic [7:0]  hst_wdata,
  output logic [7:0]  hst_rdata,
  output logic        fetch_valid,
  input  logic        fetch_ready,
  output logic [31:0] fetch_addr,
  input  logic        fetch_last,
  input  logic        segment_done,
  input  logic        drive_irq,
  input  logic        xfer_err,
  output logic        active,
  output logic        dir_write,
  output logic        flush
);

  localparam int          PTR_W  = 32;
  localparam int          NBYTES = PTR_W / 8;
  localparam logic [31:0] STEP   = 32'd8;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER} state_t;

  state_t             state;
  logic               run_q, dir_q, en1_q, en0_q, irq_q, err_q, last_q, flush_q;
  logic [PTR_W-1:0]   ptr_q;

  wire wr_cmd    = hst_wr && (hst_addr == 3'd0);
  wire wr_sts    = hst_wr && (hst_addr == 3'd2);
  wire start     = wr_cmd && hst_wdata[0] && !run_q && (state == S_IDLE);
  wire abort     = wr_cmd && !hst_wdata[0] && (state != S_IDLE);
  wire fetch_acc = (state == S_FETCH) && fetch_ready;

  assign active      = (state != S_IDLE);
  assign fetch_valid = (state == S_FETCH);
  assign fetch_addr  = {ptr_q[PTR_W-1:2], 2'b00};
  assign dir_write   = dir_q;
  assign flush       = flush_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      run_q   <= 1'b0;
      dir_q   <= 1'b0;
      last_q  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= abort;
      if (wr_cmd) run_q <= hst_wdata[0];
      if (wr_cmd && !active) dir_q <= hst_wdata[3];
      if (abort) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE:  if (start) state <= S_FETCH;
          S_FETCH: if (fetch_ready) begin
                     last_q <= fetch_last;
                     state  <= S_XFER;
                   end
          S_XFER:  if (segment_done) state <= last_q ? S_IDLE : S_FETCH;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en1_q <= 1'b0;
      en0_q <= 1'b0;
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (wr_sts) begin
        en1_q <= hst_wdata[6];
        en0_q <= hst_wdata[5];
      end
      if (drive_irq)                  irq_q <= 1'b1;
      else if (wr_sts && hst_wdata[2]) irq_q <= 1'b0;
      if (xfer_err)                   err_q <= 1'b1;
      else if (wr_sts && hst_wdata[1]) err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (fetch_acc && !abort) begin
      ptr_q <= ptr_q + STEP;
    end else if (hst_wr && hst_addr[2] && !active) begin
      for (int b = 0; b < NBYTES; b++)
        if (hst_addr[1:0] == 2'(b)) ptr_q[b*8 +: 8] <= hst_wdata;
      ptr_q[1:0] <= 2'b00;
    end
  end

  always_comb begin
    case (hst_addr)
      3'd0:    hst_rdata = {4'b0000, dir_q, 2'b00, run_q};
      3'd2:    hst_rdata = {SIMPLEX, en1_q, en0_q, 2'b00, irq_q, err_q, active};
      3'd4:    hst_rdata = {ptr_q[7:2], 2'b00};
      3'd5:    hst_rdata = ptr_q[15:8];
      3'd6:    hst_rdata = ptr_q[23:16];
      3'd7:    hst_rdata = ptr_q[31:24];
      default: hst_rdata = 8'h00;
    endcase
  end

  // R9
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !abort) |=> (fetch_valid && $stable(fetch_addr)));

  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && !abort) |=> (!fetch_valid && fetch_addr == $past(fetch_addr) + STEP));

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !(wr_sts && hst_wdata[2])) |=> irq_q);

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> err_q);

  // R11
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> $stable(dir_write));

  // R4
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_addr == 3'd1 || hst_addr == 3'd3) |-> (hst_rdata == 8'h00));

  // R12
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!active && !$past(flush)));

endmodule

// File: tb/dma_chan_ctl_tb.sv
module dma_chan_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hst_wr = 1'b0;
  logic [2:0] hst_addr = 3'd0;
  logic [7:0] hst_wdata = 8'h00, hst_rdata;
  logic fetch_valid, fetch_ready = 1'b0, fetch_last = 1'b0, segment_done = 1'b0;
  logic [31:0] fetch_addr;
  logic drive_irq = 1'b0, xfer_err = 1'b0;
  logic active, dir_write, flush;
  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctl #(.SIMPLEX(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_addr(fetch_addr), .fetch_last(fetch_last),
    .segment_done(segment_done), .drive_irq(drive_irq), .xfer_err(xfer_err),
    .active(active), .dir_write(dir_write), .flush(flush));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(posedge clk); #1;
    hst_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    hst_addr = a; #1; d = hst_rdata;
  endtask

  task automatic rd_ptr(output logic [31:0] p);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      rd(3'(4 + k), b);
      p[k*8 +: 8] = b;
    end
  endtask

  task automatic wr_ptr(input logic [31:0] p);
    for (int k = 0; k < 4; k++) wr(3'(4 + k), p[k*8 +: 8]);
  endtask

  initial begin
    logic [7:0] d;
    logic [31:0] p, base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reset read", {24'd0, d}, (a == 2) ? 32'h80 : 32'h00);
    end
    chk("R1 idle outputs", {28'd0, fetch_valid, active, dir_write, flush}, 32'd0);

    // R2
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, 8'(v) & 8'hFE);
      rd(3'd0, d);
      chk("R2 cmd readback", {24'd0, d}, 32'(v & 8'h08));
      chk("R2 dir_write", {31'd0, dir_write}, 32'((v >> 3) & 1));
    end
    wr(3'd0, 8'h00);

    // R3
    for (int v = 0; v < 256; v++) begin
      wr(3'd2, 8'(v));
      rd(3'd2, d);
      chk("R3 status readback", {24'd0, d}, 32'((v & 8'h60) | 8'h80));
    end

    // R4
    wr(3'd2, 8'h40);
    wr_ptr(32'h1234_5678);
    for (int v = 0; v < 256; v++) begin
      wr(3'((v & 1) ? 3 : 1), 8'(v));
      rd(3'd1, d); chk("R4 offset1", {24'd0, d}, 32'd0);
      rd(3'd3, d); chk("R4 offset3", {24'd0, d}, 32'd0);
    end
    rd(3'd2, d); chk("R4 status untouched", {24'd0, d}, 32'hC0);
    rd(3'd0, d); chk("R4 cmd untouched", {24'd0, d}, 32'd0);
    rd_ptr(p); chk("R4 ptr untouched", p, 32'h1234_5678);

    // R5
    for (int i = 0; i < 16; i++) begin
      base = 32'h0F1E_2D3C * 32'(i + 1) + 32'(i);
      wr_ptr(base);
      rd_ptr(p);
      chk("R5 ptr readback", p, base & 32'hFFFF_FFFC);
    end
    wr(3'd5, 8'hAB);
    rd_ptr(p);
    chk("R5 single byte", p, {base[31:16], 8'hAB, base[7:2], 2'b00});

    // R6 / R7
    wr(3'd2, 8'h00);
    @(negedge clk); drive_irq = 1'b1; tick(); drive_irq = 1'b0;
    rd(3'd2, d); chk("R6 irq set", {24'd0, d}, 32'h84);
    wr(3'd2, 8'h00); rd(3'd2, d); chk("R6 write0 keeps", {24'd0, d}, 32'h84);
    wr(3'd2, 8'h04); rd(3'd2, d); chk("R6 w1c", {24'd0, d}, 32'h80);
    @(negedge clk); xfer_err = 1'b1; tick(); xfer_err = 1'b0;
    rd(3'd2, d); chk("R7 err set", {24'd0, d}, 32'h82);
    wr(3'd2, 8'h04); rd(3'd2, d); chk("R7 other w1c keeps", {24'd0, d}, 32'h82);
    wr(3'd2, 8'h02); rd(3'd2, d); chk("R7 w1c", {24'd0, d}, 32'h80);
    @(negedge clk);
    drive_irq = 1'b1; xfer_err = 1'b1;
    hst_wr = 1'b1; hst_addr = 3'd2; hst_wdata = 8'h06;
    tick();
    hst_wr = 1'b0; drive_irq = 1'b0; xfer_err = 1'b0;
    rd(3'd2, d); chk("R6 R7 set wins", {24'd0, d}, 32'h86);
    wr(3'd2, 8'h06);

    // R8 R9 R10 R11
    base = 32'h0000_1000;
    wr_ptr(base);
    wr(3'd0, 8'h09);
    chk("R8 active", {31'd0, active}, 32'd1);
    chk("R8 dir", {31'd0, dir_write}, 32'd1);
    rd(3'd2, d); chk("R8 status bit0", {24'd0, d}, 32'h81);
    for (int e = 0; e < 5; e++) begin
      chk("R10 fetch valid", {31'd0, fetch_valid}, 32'd1);
      chk("R10 fetch addr", fetch_addr, base + 32'(8 * e));
      for (int s = 0; s < 3; s++) begin
        tick();
        chk("R9 hold valid", {31'd0, fetch_valid}, 32'd1);
        chk("R9 hold addr", fetch_addr, base + 32'(8 * e));
      end
      fetch_ready = 1'b1; fetch_last = (e == 4);
      tick();
      fetch_ready = 1'b0; fetch_last = 1'b0;
      chk("R9 valid drops", {31'd0, fetch_valid}, 32'd0);
      rd_ptr(p); chk("R9 ptr advanced", p, base + 32'(8 * (e + 1)));
      if (e == 2) begin
        wr(3'd0, 8'h01);
        rd(3'd0, d); chk("R11 dir write ignored", {24'd0, d}, 32'h09);
        wr(3'd4, 8'hF0);
        rd_ptr(p); chk("R11 ptr write ignored", p, base + 32'd24);
      end
      tick(); tick();
      chk("R10 waits for segment", {30'd0, fetch_valid, active}, 32'd1);
      @(negedge clk); segment_done = 1'b1; tick(); segment_done = 1'b0;
    end
    chk("R10 end of table clears active", {31'd0, active}, 32'd0);
    chk("R10 no fetch after last", {31'd0, fetch_valid}, 32'd0);

    // R8
    wr(3'd0, 8'h09);
    chk("R8 no restart when run already 1", {31'd0, active}, 32'd0);

    // R12
    wr(3'd0, 8'h00);
    chk("R12 clear while idle no flush", {31'd0, flush}, 32'd0);
    wr(3'd0, 8'h01);
    chk("R8 restart addr", fetch_addr, base + 32'd40);
    chk("R8 dir read", {31'd0, dir_write}, 32'd0);
    @(negedge clk); fetch_ready = 1'b1; tick(); fetch_ready = 1'b0;
    wr(3'd0, 8'h00);
    chk("R12 abort active", {31'd0, active}, 32'd0);
    chk("R12 abort flush", {31'd0, flush}, 32'd1);
    tick();
    chk("R12 flush one cycle", {31'd0, flush}, 32'd0);
    @(negedge clk); segment_done = 1'b1; tick(); segment_done = 1'b0;
    chk("R12 no fetch after abort", {30'd0, fetch_valid, active}, 32'd0);
    rd_ptr(p); chk("R12 ptr after abort", p, base + 32'd48);
    wr(3'd0, 8'h01);
    chk("R12 fresh start addr", fetch_addr, base + 32'd48);
    wr(3'd0, 8'h00);
    chk("R12 abort from fetch", {30'd0, fetch_valid, active}, 32'd0);
    rd_ptr(p); chk("R12 no advance on abort", p, base + 32'd48);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule